// File: doc/BRIEF.md
# Debug Memory Access Port

This block sits behind a debugger-side front end. The front end has already turned the serial line protocol into parallel words. Each request arrives as a control byte with a 32-bit data word. The block answers every request one cycle later with an acknowledge code and a read word. Memory is never addressed directly. The debugger first loads a target address into a transfer address register. It then accesses a data register, and that access starts one 32-bit read or write on a valid/ready memory-mapped bus master port.

Bus transfers are posted. The data register access is acknowledged at once and the transfer runs in the background. A read result lands in a read buffer, which a later request can collect. While a transfer is outstanding, every new request is refused with a WAIT acknowledge so that the debugger retries it. A bus error latches a sticky flag. The flag blocks all access-port traffic with a FAULT acknowledge until the debugger clears it.

Top module: `dbg_mem_port`

## Requirements
- R1: Control bit 0 picks the register set (1 = access-port side, 0 = debug-port side). Bit 1 picks the direction (0 = write, 1 = read). Bits [3:2] pick the word offset 0x00/0x04/0x08/0x0C. Bits [7:4] are ignored.
- R2: Each request sampled with `req_valid` high gets exactly one response, with `rsp_valid` high on the following cycle only. The acknowledge is one-hot: OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100. Write, WAIT and FAULT responses carry zero read data.
- R3: The bank register is at debug-port offset 0x08. A write takes the bank number from data bits [7:4]. A read returns the bank in bits [7:4] and zeros elsewhere. When the bank is not 0, every access-port offset is unimplemented.
- R4: The transfer address register is at access-port bank 0, offset 0x04. It is written with the full data word and reads back that word.
- R5: Writing access-port bank 0 offset 0x0C issues exactly one bus write of the data word to the transfer address. Control 0x05 with 0xE000ED0C, followed by control 0x0D with 0x05FA0004, writes 0x05FA0004 to 0xE000ED0C.
- R6: Reading offset 0x0C issues one bus read from the transfer address. Its response returns the read buffer as it stood before this read. The bus result, when error-free, is stored in the read buffer, which is also visible at debug-port offset 0x0C.
- R7: Once `m_req_valid` rises, it stays high with address, write flag and write data unchanged until a cycle with `m_req_ready` high.
- R8: From the cycle a transfer is launched through the cycle its bus response is taken, every request gets WAIT and changes no register and starts no transfer.
- R9: A bus error sets a sticky flag, read at debug-port offset 0x00 bit 0. The read buffer is left unchanged. While the flag is set, every access-port request gets FAULT and has no effect. Writing debug-port offset 0x00 with bit 0 = 1 clears the flag.
- R10: Unimplemented registers (debug-port 0x04, access-port bank 0 offsets 0x00/0x08, any offset in a nonzero bank) read as zero, ignore writes, and acknowledge OK.
- R11: After reset there is no bus request and no response, and the bank, transfer address, read buffer and sticky flag are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ctrl | input | 8 | Control byte |
| req_wdata | input | 32 | Request data word |
| rsp_valid | output | 1 | Response present |
| rsp_ack | output | 3 | One-hot acknowledge |
| rsp_rdata | output | 32 | Response read data |
| m_req_valid | output | 1 | Bus request valid |
| m_req_ready | input | 1 | Bus request accepted |
| m_req_write | output | 1 | Bus request is a write |
| m_req_addr | output | 32 | Bus address |
| m_req_wdata | output | 32 | Bus write data |
| m_rsp_valid | input | 1 | Bus response present; the partner sends it at least one cycle after acceptance |
| m_rsp_rdata | input | 32 | Bus read data |
| m_rsp_err | input | 1 | Bus response error |

## Verification
On every cycle, the assertions check the shape of the response channel: one response per request, a single hot acknowledge bit, and WAIT whenever a transfer is outstanding. They also check that a bus request holds steady until accepted, that a transfer only starts from an idle request, and that the sticky flag only rises on an erroring bus response. Register contents can only be seen through the bench's scenarios: the read-back of the transfer address and bank, the posted read-buffer ordering, the exact single bus write for the reset-vector example, and the proof that refused or faulted requests leave registers and bus untouched.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  localparam int ACK_W = 3;
  localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
  localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
  localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DP_STAT,
    SEL_DP_BANK,
    SEL_DP_RDBUF,
    SEL_AP_TAR,
    SEL_AP_DRW
  } sel_e;

  typedef enum logic [1:0] {
    BST_IDLE,
    BST_REQ,
    BST_RSP
  } bus_st_e;
endpackage

// File: rtl/dmp_decode.sv
module dmp_decode #(
  parameter int BANK_W = 4
) (
  input  logic [3:0]        ctrl,
  input  logic [BANK_W-1:0] bank,
  output logic              is_ap,
  output logic              is_rd,
  output dmp_pkg::sel_e     sel
);
  import dmp_pkg::*;

  logic [1:0] off;

  always_comb begin
    is_ap = ctrl[0];
    is_rd = ctrl[1];
    off   = ctrl[3:2];
    sel   = SEL_NONE;
    if (!is_ap) begin
      unique case (off)
        2'd0: sel = SEL_DP_STAT;
        2'd2: sel = SEL_DP_BANK;
        2'd3: sel = SEL_DP_RDBUF;
        default: sel = SEL_NONE;
      endcase
    end else if (bank == '0) begin
      unique case (off)
        2'd1: sel = SEL_AP_TAR;
        2'd3: sel = SEL_AP_DRW;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dmp_regs.sv
module dmp_regs #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int BANK_W  = 4,
  parameter int BANK_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  dmp_pkg::sel_e     sel,
  input  logic [DW-1:0]     wdata,
  input  logic              done,
  input  logic              done_err,
  input  logic              done_rd,
  input  logic [DW-1:0]     done_rdata,
  output logic [BANK_W-1:0] bank,
  output logic [AW-1:0]     tar,
  output logic [DW-1:0]     rdbuf,
  output logic              sticky,
  output logic [DW-1:0]     rd_data
);
  import dmp_pkg::*;

  logic [BANK_W-1:0] bank_d;
  logic [AW-1:0]     tar_d;
  logic [DW-1:0]     rdbuf_d;
  logic              sticky_d;
  logic              bank_en, tar_en, rdbuf_en, sticky_en;

  always_comb begin
    bank_en   = wr_en && (sel == SEL_DP_BANK);
    tar_en    = wr_en && (sel == SEL_AP_TAR);
    rdbuf_en  = done && done_rd && !done_err;
    sticky_en = (done && done_err) || (wr_en && (sel == SEL_DP_STAT));
    bank_d    = wdata[BANK_LSB +: BANK_W];
    tar_d     = wdata[AW-1:0];
    rdbuf_d   = done_rdata;
    if (done && done_err) sticky_d = 1'b1;
    else                  sticky_d = sticky && !wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank   <= '0;
      tar    <= '0;
      rdbuf  <= '0;
      sticky <= 1'b0;
    end else begin
      if (bank_en)   bank   <= bank_d;
      if (tar_en)    tar    <= tar_d;
      if (rdbuf_en)  rdbuf  <= rdbuf_d;
      if (sticky_en) sticky <= sticky_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (sel)
      SEL_DP_STAT:  rd_data[0] = sticky;
      SEL_DP_BANK:  rd_data[BANK_LSB +: BANK_W] = bank;
      SEL_DP_RDBUF: rd_data = rdbuf;
      SEL_AP_TAR:   rd_data[AW-1:0] = tar;
      SEL_AP_DRW:   rd_data = rdbuf;
      default:      rd_data = '0;
    endcase
  end

  p_sticky_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky) |-> $past(done && done_err));
endmodule

// File: rtl/dmp_bus_master.sv
module dmp_bus_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_wr,
  input  logic [AW-1:0] launch_addr,
  input  logic [DW-1:0] launch_wdata,
  output logic          busy,
  output logic          done,
  output logic          done_err,
  output logic          done_rd,
  output logic [DW-1:0] done_rdata,
  output logic          m_req_valid,
  input  logic          m_req_ready,
  output logic          m_req_write,
  output logic [AW-1:0] m_req_addr,
  output logic [DW-1:0] m_req_wdata,
  input  logic          m_rsp_valid,
  input  logic [DW-1:0] m_rsp_rdata,
  input  logic          m_rsp_err
);
  import dmp_pkg::*;

  bus_st_e       st_q, st_d;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          cap_en;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    unique case (st_q)
      BST_IDLE: if (launch) begin
        st_d   = BST_REQ;
        cap_en = 1'b1;
      end
      BST_REQ:  if (m_req_ready) st_d = BST_RSP;
      BST_RSP:  if (m_rsp_valid) st_d = BST_IDLE;
      default:  st_d = BST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      wr_q    <= launch_wr;
      addr_q  <= launch_addr;
      wdata_q <= launch_wdata;
    end
  end

  always_comb begin
    busy        = (st_q != BST_IDLE);
    m_req_valid = (st_q == BST_REQ);
    m_req_write = wr_q;
    m_req_addr  = addr_q;
    m_req_wdata = wdata_q;
    done        = (st_q == BST_RSP) && m_rsp_valid;
    done_err    = m_rsp_err;
    done_rd     = !wr_q;
    done_rdata  = m_rsp_rdata;
  end

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_ready) |=>
      (m_req_valid && $stable(m_req_addr) && $stable(m_req_wdata) && $stable(m_req_write)));

  p_launch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req_valid) |-> $past(launch && !busy));
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int BANK_W   = 4,
  parameter int BANK_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [7:0]    req_ctrl,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [2:0]    rsp_ack,
  output logic [DW-1:0] rsp_rdata,
  output logic          m_req_valid,
  input  logic          m_req_ready,
  output logic          m_req_write,
  output logic [AW-1:0] m_req_addr,
  output logic [DW-1:0] m_req_wdata,
  input  logic          m_rsp_valid,
  input  logic [DW-1:0] m_rsp_rdata,
  input  logic          m_rsp_err
);
  import dmp_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic unused_ctrl_hi;
  assign unused_ctrl_hi = ^req_ctrl[7:4];

  logic              is_ap, is_rd;
  sel_e              sel;
  logic [BANK_W-1:0] bank;
  logic [AW-1:0]     tar;
  logic [DW-1:0]     rdbuf, rd_data;
  logic              sticky, busy;
  logic              done, done_err, done_rd;
  logic [DW-1:0]     done_rdata;
  logic              blocked, faulted, accept, wr_en, launch;

  dmp_decode #(.BANK_W(BANK_W)) u_dec (
    .ctrl  (req_ctrl[3:0]),
    .bank  (bank),
    .is_ap (is_ap),
    .is_rd (is_rd),
    .sel   (sel)
  );

  always_comb begin
    blocked = busy;
    faulted = !busy && is_ap && sticky;
    accept  = req_valid && !blocked && !faulted;
    wr_en   = accept && !is_rd;
    launch  = accept && (sel == SEL_AP_DRW);
  end

  dmp_regs #(.AW(AW), .DW(DW), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .sel        (sel),
    .wdata      (req_wdata),
    .done       (done),
    .done_err   (done_err),
    .done_rd    (done_rd),
    .done_rdata (done_rdata),
    .bank       (bank),
    .tar        (tar),
    .rdbuf      (rdbuf),
    .sticky     (sticky),
    .rd_data    (rd_data)
  );

  dmp_bus_master #(.AW(AW), .DW(DW)) u_bus (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .launch       (launch),
    .launch_wr    (!is_rd),
    .launch_addr  (tar),
    .launch_wdata (req_wdata),
    .busy         (busy),
    .done         (done),
    .done_err     (done_err),
    .done_rd      (done_rd),
    .done_rdata   (done_rdata),
    .m_req_valid  (m_req_valid),
    .m_req_ready  (m_req_ready),
    .m_req_write  (m_req_write),
    .m_req_addr   (m_req_addr),
    .m_req_wdata  (m_req_wdata),
    .m_rsp_valid  (m_rsp_valid),
    .m_rsp_rdata  (m_rsp_rdata),
    .m_rsp_err    (m_rsp_err)
  );

  logic          rsp_valid_d;
  logic [2:0]    rsp_ack_d;
  logic [DW-1:0] rsp_rdata_d;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_ack_d   = '0;
    rsp_rdata_d = '0;
    if (req_valid) begin
      if (blocked)      rsp_ack_d = ACK_WAIT;
      else if (faulted) rsp_ack_d = ACK_FAULT;
      else begin
        rsp_ack_d = ACK_OK;
        if (is_rd) rsp_rdata_d = rd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_ack   <= rsp_ack_d;
      rsp_rdata <= rsp_rdata_d;
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> rsp_valid);
  p_rsp_only_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !rsp_valid);
  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_valid |-> ($countones(rsp_ack) == 1));
  p_wait_busy_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && m_req_valid) |=> (rsp_ack == ACK_WAIT));
endmodule

// File: tb/tb_dbg_mem_port.sv
module tb_dbg_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OK = 3'b001, WT = 3'b010, FL = 3'b100;
  localparam logic [31:0] RD_KEY = 32'h5A5A_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_ctrl = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [2:0] rsp_ack;
  logic [31:0] rsp_rdata;
  logic m_req_valid, m_req_write;
  logic m_req_ready = 1'b0;
  logic [31:0] m_req_addr, m_req_wdata;
  logic m_rsp_valid = 1'b0;
  logic [31:0] m_rsp_rdata = '0;
  logic m_rsp_err = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 0;

  int ready_lat = 0, rsp_lat = 0;
  bit slv_err = 0;
  int txn_count = 0, hold_viol = 0;
  logic [31:0] last_addr = '0, last_wdata = '0;
  logic last_write = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_mem_port dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ctrl(req_ctrl), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_write(m_req_write),
    .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err)
  );

  // bus partner model, driven at falling edges
  initial begin
    int wcnt = 0, rcnt = 0;
    bit seen = 0, rpend = 0;
    logic [31:0] snap_a = '0, snap_d = '0;
    logic snap_w = 1'b0;
    forever begin
      @(negedge clk);
      m_rsp_valid = 1'b0;
      if (m_req_ready) begin
        m_req_ready = 1'b0;
        rpend = 1;
        rcnt = rsp_lat;
      end
      if (rpend) begin
        if (rcnt == 0) begin
          m_rsp_valid = 1'b1;
          m_rsp_rdata = last_addr ^ RD_KEY;
          m_rsp_err   = slv_err;
          rpend = 0;
        end else rcnt--;
      end
      if (m_req_valid) begin
        if (!seen) begin
          seen = 1; snap_a = m_req_addr; snap_d = m_req_wdata; snap_w = m_req_write;
        end else if (snap_a !== m_req_addr || snap_d !== m_req_wdata || snap_w !== m_req_write)
          hold_viol++;
        if (wcnt >= ready_lat) begin
          m_req_ready = 1'b1;
          txn_count++;
          last_addr = m_req_addr; last_wdata = m_req_wdata; last_write = m_req_write;
          seen = 0; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [31:0] d,
                      input logic [2:0] eack, input logic [31:0] erd, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_ctrl = c; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, req, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk(rsp_ack === eack && rsp_rdata === erd, req, "ack/rdata",
        {rsp_ack, rsp_rdata[28:0]}, {eack, erd[28:0]});
    @(negedge clk);
    chk(rsp_valid === 1'b0, req, "single response", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R11: state after reset
  task automatic t_reset;
    chk(rsp_valid === 1'b0 && m_req_valid === 1'b0, "R11", "outputs idle",
        {30'b0, rsp_valid, m_req_valid}, 32'd0);
    xfer(8'h0A, 0, OK, 32'h0, "R11");   // bank
    xfer(8'h07, 0, OK, 32'h0, "R11");   // transfer address
    xfer(8'h0E, 0, OK, 32'h0, "R11");   // read buffer
    xfer(8'h02, 0, OK, 32'h0, "R11");   // sticky status
  endtask

  // R5, R4, R1: reset-vector style write
  task automatic t_example;
    int base = txn_count;
    xfer(8'h05, 32'hE000ED0C, OK, 0, "R5");
    xfer(8'h0D, 32'h05FA0004, OK, 0, "R5");
    idle(8);
    chk(txn_count == base + 1, "R5", "bus txn count", txn_count, base + 1);
    chk(last_write === 1'b1 && last_addr === 32'hE000ED0C, "R5", "bus addr", last_addr, 32'hE000ED0C);
    chk(last_wdata === 32'h05FA0004, "R5", "bus data", last_wdata, 32'h05FA0004);
    xfer(8'h07, 0, OK, 32'hE000ED0C, "R4");
    xfer(8'hF7, 0, OK, 32'hE000ED0C, "R1");   // upper control bits ignored
  endtask

  // R8, R7: slow bus, requests refused while outstanding
  task automatic t_wait;
    int base = txn_count;
    ready_lat = 3; rsp_lat = 2;
    xfer(8'h0D, 32'hCAFE0001, OK, 0, "R8");
    xfer(8'h05, 32'h00001234, WT, 0, "R8");
    xfer(8'h0D, 32'h11111111, WT, 0, "R8");
    idle(12);
    chk(txn_count == base + 1, "R8", "one txn only", txn_count, base + 1);
    chk(last_wdata === 32'hCAFE0001, "R8", "bus data", last_wdata, 32'hCAFE0001);
    chk(hold_viol == 0, "R7", "request held stable", hold_viol, 0);
    xfer(8'h07, 0, OK, 32'hE000ED0C, "R8");
    ready_lat = 0; rsp_lat = 0;
  endtask

  // R6: posted read and read buffer
  task automatic t_read;
    xfer(8'h05, 32'h00000100, OK, 0, "R6");
    xfer(8'h0F, 0, OK, 32'h0, "R6");
    idle(6);
    chk(last_write === 1'b0 && last_addr === 32'h100, "R6", "bus read addr", last_addr, 32'h100);
    xfer(8'h0E, 0, OK, 32'h5A5A0100, "R6");
    xfer(8'h05, 32'h00000200, OK, 0, "R6");
    xfer(8'h0F, 0, OK, 32'h5A5A0100, "R6");
    idle(6);
    xfer(8'h0E, 0, OK, 32'h5A5A0200, "R6");
  endtask

  // R3, R10: bank select and unimplemented registers
  task automatic t_bank;
    int base = txn_count;
    xfer(8'h08, 32'h000000F5, OK, 0, "R3");
    xfer(8'h0A, 0, OK, 32'h000000F0, "R3");
    xfer(8'h07, 0, OK, 32'h0, "R3");
    xfer(8'h0D, 32'h0BADBEEF, OK, 0, "R3");
    idle(4);
    chk(txn_count == base, "R3", "no bus txn in bank F", txn_count, base);
    xfer(8'h08, 32'h0, OK, 0, "R3");
    xfer(8'h07, 0, OK, 32'h00000200, "R3");
    xfer(8'h04, 32'hFFFFFFFF, OK, 0, "R10");
    xfer(8'h06, 0, OK, 32'h0, "R10");
    xfer(8'h01, 32'hFFFFFFFF, OK, 0, "R10");
    xfer(8'h03, 0, OK, 32'h0, "R10");
    xfer(8'h0B, 0, OK, 32'h0, "R10");
    xfer(8'h07, 0, OK, 32'h00000200, "R10");
  endtask

  // R9: sticky bus error
  task automatic t_error;
    int base;
    slv_err = 1;
    xfer(8'h0F, 0, OK, 32'h5A5A0200, "R9");
    idle(6);
    slv_err = 0;
    xfer(8'h02, 0, OK, 32'h1, "R9");
    xfer(8'h0E, 0, OK, 32'h5A5A0200, "R9");
    base = txn_count;
    xfer(8'h07, 0, FL, 32'h0, "R9");
    xfer(8'h05, 32'h00000999, FL, 0, "R9");
    xfer(8'h0D, 32'h1, FL, 0, "R9");
    idle(4);
    chk(txn_count == base, "R9", "no txn while faulted", txn_count, base);
    xfer(8'h00, 32'h0, OK, 0, "R9");
    xfer(8'h02, 0, OK, 32'h1, "R9");
    xfer(8'h00, 32'h1, OK, 0, "R9");
    xfer(8'h02, 0, OK, 32'h0, "R9");
    xfer(8'h07, 0, OK, 32'h00000200, "R9");
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    t_reset;
    t_example;
    t_wait;
    t_read;
    t_bank;
    t_error;
    idle(2);
    summary;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary;
  end
endmodule